// File: doc/BRIEF.md
# Zone Fault Recovery Controller

This controller sits between the fault detectors of a set of reconfigurable zones and the engine that rewrites a zone's configuration. Each detector pulse latches a per-zone fault flag. The controller serves these flags one at a time, lowest zone first. For each one it raises a repair request that carries the zone number, and it holds that request until the engine answers with a done pulse. The done pulse clears the flag and opens a watch window of programmable length for that zone.

A zone that faults again inside its watch window is declared permanently failed. The controller then looks for a spare zone. A spare is the lowest-numbered zone that is not failed, is not the failed zone, and either holds nothing or holds a sub-band that has no replica elsewhere. The controller copies the failed zone's sub-band entry into the spare, empties the failed zone's entry, and asks the engine to load the spare. It also toggles a replica-select bit so that the output stage takes its result from a healthy copy. When no spare exists, it raises a sticky no-spare error instead.

Top module: `zfr_top`

## Requirements
- R1: A one-cycle pulse on `fault_i[z]` sets `flag_o[z]` on that clock edge. A fault pulse on a zone marked in `perm_o` has no effect on its flag.
- R2: At most one request is outstanding. When flags are pending and the controller is idle, it raises `rcfg_req` with `rcfg_zone` set to the lowest pending zone. Both stay unchanged until `rcfg_done` is seen.
- R3: While `rcfg_req` is high, a `rcfg_done` pulse clears the flag of the requested zone and drops `rcfg_req` on the following cycle.
- R4: A done pulse at edge d loads a watch window of `win_len` edges. A fault on that zone sampled at edges d+1 through d+`win_len` marks the zone permanent. A fault sampled later starts an ordinary repair of the same zone.
- R5: When a zone becomes permanent and a spare exists, the spare is chosen by the rule above. The spare's field takes the failed zone's field, the failed zone's valid bit is cleared, and a request is raised for the spare zone. Zone i's field is `place_o[i*3 +: 3]`, where bit 2 is valid and bits 1:0 are the sub-band index.
- R6: `rep_sel` toggles exactly once per relocation and changes at no other time.
- R7: When a zone becomes permanent and no spare exists, `nospare_o` rises and stays high. No request is raised and the placement word is unchanged.
- R8: `cfg_we` loads `cfg_place` into `place_o` on the next edge and clears `nospare_o`.
- R9: After reset, flags, `perm_o`, `rcfg_req`, `rep_sel`, `nospare_o` and `place_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fault_i | input | NZ | Per-zone fault pulses |
| win_len | input | CW | Watch window length in cycles |
| cfg_we | input | 1 | Load placement word |
| cfg_place | input | NZ*(SBW+1) | Placement word to load |
| rcfg_done | input | 1 | Engine finished the current request |
| rcfg_req | output | 1 | Repair or load request to engine |
| rcfg_zone | output | log2(NZ) | Zone addressed by the request |
| flag_o | output | NZ | Latched fault flags |
| perm_o | output | NZ | Zones marked permanently failed |
| place_o | output | NZ*(SBW+1) | Current placement word |
| rep_sel | output | 1 | Replica select for the output stage |
| nospare_o | output | 1 | Sticky relocation failure |

## Verification
A wrong watch counter shows up one repair later. A refault then starts a normal request for the same zone instead of a relocation, or the reverse happens, and both `rcfg_zone` and `perm_o` differ within two cycles of the fault pulse. A corrupted arbitration or spare choice shows as a wrong `rcfg_zone` on the first request after the decision. A wrong placement edit is visible on `place_o` at once. The flag register can be seen directly, so a flag that is not cleared or not ignored appears on `flag_o` one edge after the done or fault pulse.

// File: rtl/zfr_pkg.sv
package zfr_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } zfr_st_e;
endpackage

// File: rtl/zfr_prio_pick.sv
module zfr_prio_pick #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic [N-1:0]  req,
  output logic          hit,
  output logic [IW-1:0] idx
);
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        hit = 1'b1;
        idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/zfr_zone_watch.sv
module zfr_zone_watch #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fault,
  input  logic          ignore,
  input  logic          clr,
  input  logic          load,
  input  logic [CW-1:0] win_len,
  output logic          flag,
  output logic          refault
);
  logic          flag_q, flag_d;
  logic          ref_q, ref_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          set_v, win_act;

  always_comb begin
    set_v   = fault & ~ignore;
    win_act = (cnt_q != '0);
    flag_d  = set_v | (flag_q & ~clr);
    ref_d   = (set_v & win_act) | (ref_q & ~clr);
    if (load)         cnt_d = win_len;
    else if (win_act) cnt_d = cnt_q - CW'(1);
    else              cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      ref_q  <= 1'b0;
      cnt_q  <= '0;
    end else begin
      flag_q <= flag_d;
      ref_q  <= ref_d;
      cnt_q  <= cnt_d;
    end
  end

  assign flag    = flag_q;
  assign refault = ref_q;

  AST_REF_HAS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    ref_q |-> flag_q); // R4
  AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !fault) |=> !flag_q); // R3
  AST_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (ignore && !flag_q && !clr) |=> !flag_q); // R1
endmodule

// File: rtl/zfr_top.sv
module zfr_top #(
  parameter int NZ  = 4,
  parameter int SBW = 2,
  parameter int CW  = 8,
  localparam int ZW = (NZ > 1) ? $clog2(NZ) : 1,
  localparam int SW = SBW + 1,
  localparam int PW = NZ * SW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NZ-1:0] fault_i,
  input  logic [CW-1:0] win_len,
  input  logic          cfg_we,
  input  logic [PW-1:0] cfg_place,
  input  logic          rcfg_done,
  output logic          rcfg_req,
  output logic [ZW-1:0] rcfg_zone,
  output logic [NZ-1:0] flag_o,
  output logic [NZ-1:0] perm_o,
  output logic [PW-1:0] place_o,
  output logic          rep_sel,
  output logic          nospare_o
);
  import zfr_pkg::*;

  zfr_st_e       st_q, st_d;
  logic [ZW-1:0] zone_q, zone_d;
  logic [PW-1:0] place_q, place_d;
  logic [NZ-1:0] perm_q, perm_d;
  logic          sel_q, sel_d;
  logic          nosp_q, nosp_d;

  logic [NZ-1:0] flag_w, ref_w, clr_v, load_v;
  logic [NZ-1:0] pend, cand, vld, shared;
  logic          phit, shit;
  logic [ZW-1:0] pz, sz;

  // per-zone flag and watch window
  for (genvar g = 0; g < NZ; g++) begin : g_zone
    zfr_zone_watch #(.CW(CW)) u_watch (
      .clk     (clk),
      .rst_n   (rst_n),
      .fault   (fault_i[g]),
      .ignore  (perm_q[g]),
      .clr     (clr_v[g]),
      .load    (load_v[g]),
      .win_len (win_len),
      .flag    (flag_w[g]),
      .refault (ref_w[g])
    );
    assign vld[g] = place_q[g*SW + SBW];
  end

  // a zone is shared when another valid zone carries the same sub-band
  always_comb begin
    shared = '0;
    for (int i = 0; i < NZ; i++) begin
      for (int j = 0; j < NZ; j++) begin
        if (i != j && vld[i] && vld[j] &&
            place_q[i*SW +: SBW] == place_q[j*SW +: SBW])
          shared[i] = 1'b1;
      end
    end
  end

  assign pend = flag_w & ~perm_q;

  zfr_prio_pick #(.N(NZ), .IW(ZW)) u_pend_pick (
    .req (pend),
    .hit (phit),
    .idx (pz)
  );

  always_comb begin
    for (int i = 0; i < NZ; i++)
      cand[i] = !perm_q[i] && (ZW'(i) != pz) && (!vld[i] || !shared[i]);
  end

  zfr_prio_pick #(.N(NZ), .IW(ZW)) u_spare_pick (
    .req (cand),
    .hit (shit),
    .idx (sz)
  );

  // next-state
  always_comb begin
    st_d    = st_q;
    zone_d  = zone_q;
    place_d = place_q;
    perm_d  = perm_q;
    sel_d   = sel_q;
    nosp_d  = nosp_q;
    clr_v   = '0;
    load_v  = '0;
    case (st_q)
      ST_IDLE: begin
        if (phit) begin
          if (ref_w[pz]) begin
            perm_d[pz] = 1'b1;
            clr_v[pz]  = 1'b1;
            if (shit) begin
              place_d[sz*SW +: SW]  = place_q[pz*SW +: SW];
              place_d[pz*SW + SBW]  = 1'b0;
              sel_d                 = ~sel_q;
              zone_d                = sz;
              st_d                  = ST_WAIT;
            end else begin
              nosp_d = 1'b1;
            end
          end else begin
            zone_d = pz;
            st_d   = ST_WAIT;
          end
        end
      end
      ST_WAIT: begin
        if (rcfg_done) begin
          clr_v[zone_q]  = 1'b1;
          load_v[zone_q] = 1'b1;
          st_d           = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
    if (cfg_we) begin
      place_d = cfg_place;
      nosp_d  = 1'b0;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      zone_q  <= '0;
      place_q <= '0;
      perm_q  <= '0;
      sel_q   <= 1'b0;
      nosp_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      zone_q  <= zone_d;
      place_q <= place_d;
      perm_q  <= perm_d;
      sel_q   <= sel_d;
      nosp_q  <= nosp_d;
    end
  end

  assign rcfg_req  = (st_q == ST_WAIT);
  assign rcfg_zone = zone_q;
  assign flag_o    = flag_w;
  assign perm_o    = perm_q;
  assign place_o   = place_q;
  assign rep_sel   = sel_q;
  assign nospare_o = nosp_q;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rcfg_req && !rcfg_done) |=> (rcfg_req && $stable(rcfg_zone))); // R2
  AST_REQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (rcfg_req && rcfg_done) |=> !rcfg_req); // R3
  AST_NO_REQ_PERM: assert property (@(posedge clk) disable iff (!rst_n)
    rcfg_req |-> !perm_o[rcfg_zone]); // R5
  AST_SEL_ON_RELOC: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rep_sel) |-> (rcfg_req && !$stable(perm_o))); // R6
  AST_NOSPARE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nospare_o) |-> !rcfg_req); // R7
endmodule

// File: tb/tb_zfr_top.sv
module tb_zfr_top;
  localparam int NZ  = 4;
  localparam int SBW = 2;
  localparam int CW  = 8;
  localparam int ZW  = 2;
  localparam int SW  = SBW + 1;
  localparam int PW  = NZ * SW;
  localparam int WIN = 5;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NZ-1:0] fault_i;
  logic [CW-1:0] win_len;
  logic          cfg_we;
  logic [PW-1:0] cfg_place;
  logic          rcfg_done;
  logic          rcfg_req;
  logic [ZW-1:0] rcfg_zone;
  logic [NZ-1:0] flag_o, perm_o;
  logic [PW-1:0] place_o;
  logic          rep_sel, nospare_o;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  logic [PW-1:0] m_place;
  logic [NZ-1:0] m_perm;
  logic          m_sel;

  zfr_top #(.NZ(NZ), .SBW(SBW), .CW(CW)) dut (
    .clk(clk), .rst_n(rst_n), .fault_i(fault_i), .win_len(win_len),
    .cfg_we(cfg_we), .cfg_place(cfg_place), .rcfg_done(rcfg_done),
    .rcfg_req(rcfg_req), .rcfg_zone(rcfg_zone), .flag_o(flag_o),
    .perm_o(perm_o), .place_o(place_o), .rep_sel(rep_sel),
    .nospare_o(nospare_o)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      fails  = fails + 1;
      checks = checks + 1;
      $display("FAIL watchdog R2 actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      fails = fails + 1;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int lowest(input logic [NZ-1:0] m);
    for (int i = 0; i < NZ; i++) if (m[i]) return i;
    return -1;
  endfunction

  // spare rule from R5
  function automatic int spare_of(input logic [PW-1:0] pl, input logic [NZ-1:0] pm, input int z);
    for (int i = 0; i < NZ; i++) begin
      logic v, twin;
      v = pl[i*SW + SBW];
      twin = 1'b0;
      for (int j = 0; j < NZ; j++)
        if (j != i && v && pl[j*SW + SBW] && pl[j*SW +: SBW] == pl[i*SW +: SBW]) twin = 1'b1;
      if (!pm[i] && i != z && (!v || !twin)) return i;
    end
    return -1;
  endfunction

  function automatic logic [PW-1:0] relocate(input logic [PW-1:0] pl, input int z, input int s);
    logic [PW-1:0] r;
    r = pl;
    r[s*SW +: SW] = pl[z*SW +: SW];
    r[z*SW + SBW] = 1'b0;
    return r;
  endfunction

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse(input logic [NZ-1:0] m);
    fault_i = m;
    @(negedge clk);
    fault_i = '0;
  endtask

  task automatic wait_req(input string tag, input int zexp);
    int k;
    k = 0;
    while (!rcfg_req && k < 30) begin
      @(negedge clk);
      k++;
    end
    check({tag, " req"}, rcfg_req, 1);
    check({tag, " zone"}, rcfg_zone, zexp);
  endtask

  task automatic finish_req(input string tag);
    logic [ZW-1:0] z;
    z = rcfg_zone;
    rcfg_done = 1'b1;
    @(negedge clk);
    rcfg_done = 1'b0;
    check({tag, " R3 req dropped"}, rcfg_req, 0);
    check({tag, " R3 flag cleared"}, flag_o[z], 0);
  endtask

  task automatic load_cfg(input logic [PW-1:0] p);
    cfg_place = p;
    cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
    m_place = p;
  endtask

  initial begin
    logic [PW-1:0] init_pl;
    int s;
    void'($urandom(32'd4711));
    rst_n = 1'b0; fault_i = '0; win_len = CW'(WIN); cfg_we = 1'b0;
    cfg_place = '0; rcfg_done = 1'b0;
    m_perm = '0; m_sel = 1'b0; m_place = '0;
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // R9 reset state
    check("R9 req", rcfg_req, 0);
    check("R9 flag", flag_o, 0);
    check("R9 perm", perm_o, 0);
    check("R9 place", place_o, 0);
    check("R9 sel", rep_sel, 0);
    check("R9 nospare", nospare_o, 0);

    // zones 0..2 carry sub-band 0 (triple), zone 3 carries sub-band 1 alone
    init_pl = {3'b101, 3'b100, 3'b100, 3'b100};
    load_cfg(init_pl);
    check("R8 load", place_o, init_pl);

    // R1 and R2: two simultaneous faults, lowest served first
    fault_i = 4'b0110;
    @(negedge clk);
    fault_i = '0;
    check("R1 flags set", flag_o, 4'b0110);
    wait_req("R2 first", lowest(4'b0110));
    tick(2);
    check("R2 hold zone", rcfg_zone, 1);
    finish_req("R2 first");
    wait_req("R2 second", 2);
    finish_req("R2 second");
    tick(WIN + 3);

    // R4 + R5 + R6: refault inside window relocates to single-host zone 3
    pulse(4'b0001);
    wait_req("R4 repair z0", 0);
    finish_req("R4 repair z0");
    pulse(4'b0001);
    s = spare_of(m_place, m_perm | 4'b0001, 0);
    m_perm[0] = 1'b1;
    m_place = relocate(m_place, 0, s);
    m_sel = ~m_sel;
    wait_req("R5 reloc", s);
    check("R4 perm", perm_o, m_perm);
    check("R5 place", place_o, m_place);
    check("R6 sel", rep_sel, m_sel);
    finish_req("R5 reloc");
    tick(WIN + 3);

    // R1: fault on a permanent zone is ignored
    pulse(4'b0001);
    tick(3);
    check("R1 ignored flag", flag_o[0], 0);
    check("R1 ignored req", rcfg_req, 0);

    // R7: no spare left
    pulse(4'b0010);
    wait_req("R7 repair z1", 1);
    finish_req("R7 repair z1");
    pulse(4'b0010);
    tick(3);
    m_perm[1] = 1'b1;
    check("R7 spare model", spare_of(m_place, m_perm, 1), 32'hffffffff);
    check("R7 nospare", nospare_o, 1);
    check("R7 no req", rcfg_req, 0);
    check("R7 place kept", place_o, m_place);
    check("R7 perm", perm_o, m_perm);
    check("R6 sel kept", rep_sel, m_sel);

    // R8: reload clears error
    load_cfg(init_pl);
    check("R8 nospare cleared", nospare_o, 0);
    check("R8 place", place_o, init_pl);

    // R4: fault after window is an ordinary repair
    pulse(4'b0100);
    wait_req("R4 first z2", 2);
    finish_req("R4 first z2");
    tick(WIN + 3);
    pulse(4'b0100);
    wait_req("R4 late z2", 2);
    check("R4 late not perm", perm_o, m_perm);
    finish_req("R4 late z2");
    tick(WIN + 3);

    // random fault sets on the live zones
    for (int it = 0; it < 25; it++) begin
      logic [NZ-1:0] m;
      m = NZ'($urandom) & ~m_perm;
      if (m == '0) m = 4'b1000;
      pulse(m);
      while (m != '0) begin
        int z;
        z = lowest(m);
        wait_req("R2 rand", z);
        finish_req("R3 rand");
        m[z] = 1'b0;
      end
      tick(WIN + 3);
      check("R4 rand perm", perm_o, m_perm);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule